// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block is a short queue that sits between instruction fetch and decode. It walks a fetch address forward one 32-bit word at a time and issues sequential prefetch requests. It keeps the returned words in a small ring of slots and hands decode one instruction per cycle. A slot holds one fetch word. That word can be a single 32-bit instruction, a pair of 16-bit instructions, or half of a 32-bit instruction that straddles two slots. Decode therefore takes either 2 or 4 bytes per issue.

A redirect input (flush) empties the queue in one cycle and restarts fetch at a new halfword-aligned target. Every request carries a stream tag, and the tag advances on each flush. Responses that still arrive for the abandoned stream are recognised by their old tag and discarded. Requests are only issued while the slots already filled, plus the requests still outstanding, leave room. This means a response never has to be refused.

Top module: `insn_prefetch_queue`

## Requirements
- R1: After reset, decode sees no valid instruction, `dec_pc` equals RESET_PC, and a fetch request for the word-aligned RESET_PC is offered.
- R2: Filled slots plus outstanding current-stream requests never exceed DEPTH (6 by default). With no responses returning, exactly DEPTH requests are accepted, and a full queue offers none.
- R3: Each accepted request addresses the word 4 bytes above the previous one within a stream, and carries the current stream tag.
- R4: A 16-bit parcel whose bits [1:0] equal 2'b11 starts a 32-bit instruction; any other value is a complete 16-bit instruction. `dec_len32` reports which kind is presented.
- R5: A 16-bit instruction appears on `dec_insn[15:0]` with `dec_insn[31:16]` zero. Within a word, bits [15:0] are the parcel at the lower address.
- R6: A 32-bit instruction is presented as {upper-address parcel, lower-address parcel}. When it starts in the upper half of a slot, it is presented only once the following slot also holds data.
- R7: `dec_valid` is low while the queue holds no complete instruction.
- R8: A flush empties the queue for the next cycle, redirects fetch to the target word, and makes the target halfword the next instruction issued. A decode accept in the same cycle as a flush has no effect.
- R9: Responses whose tag differs from the current stream tag are dropped and never reach decode.
- R10: `dec_pc` advances by 2 or 4 on each accepted instruction, and the issued stream equals the program order from the last redirect.
- R11: A response that completes an instruction makes it visible to decode in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Redirect: discard contents and restart at `flush_addr` |
| flush_addr | input | AW | Halfword-aligned redirect target |
| fetch_req_valid | output | 1 | Prefetch request offered |
| fetch_req_ready | input | 1 | Memory side accepts the request |
| fetch_req_addr | output | AW | Word-aligned fetch address |
| fetch_req_tag | output | TAGW | Stream tag carried with the request |
| fetch_rsp_valid | input | 1 | Fetch word returned (always accepted) |
| fetch_rsp_tag | input | TAGW | Tag of the returned word |
| fetch_rsp_data | input | 32 | Returned fetch word |
| dec_valid | output | 1 | A complete instruction is presented |
| dec_ready | input | 1 | Decode takes the presented instruction |
| dec_insn | output | 32 | Presented instruction |
| dec_len32 | output | 1 | 1 for a 32-bit instruction, 0 for 16-bit |
| dec_pc | output | AW | Address of the presented instruction |

## Verification
A fetch request and its address depend only on state, so they are due in the same cycle as the state that produces them. A returned word shows at decode one register later. A flush has emptied the queue and retargeted fetch by the next cycle. The bench drives every input at the falling edge and samples one nanosecond later. Each accept or hand-off therefore has its effect judged at the rising edge that follows. The check that a response appears at decode is made in the cycle after the delivering one, and the check that a flush has emptied the queue is made in the cycle after the flush.

// File: rtl/ipq_pkg.sv
package ipq_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef logic [HALF_W-1:0] parcel_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t insn;
        logic  len32;
    } issue_t;

    // A parcel with both low bits set opens a 32-bit instruction.
    function automatic logic parcel_is_long(parcel_t p);
        return p[1:0] == 2'b11;
    endfunction

    function automatic issue_t assemble(parcel_t lo, parcel_t hi);
        issue_t r;
        r.len32 = parcel_is_long(lo);
        r.insn  = r.len32 ? {hi, lo} : {{HALF_W{1'b0}}, lo};
        return r;
    endfunction

endpackage

// File: rtl/ipq_fetch_ctl.sv
module ipq_fetch_ctl #(
    parameter int DEPTH = 6,
    parameter int AW = 32,
    parameter int TAGW = 2,
    parameter int CW = 3,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [AW-1:0]   flush_addr,
    input  logic [CW-1:0]   count,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [AW-1:0]   req_addr,
    output logic [TAGW-1:0] req_tag,
    input  logic            rsp_valid,
    input  logic [TAGW-1:0] rsp_tag,
    output logic            push
);
    localparam logic [CW:0] LIMIT = (CW+1)'(DEPTH);

    logic [AW-1:0]   pc_q;
    logic [TAGW-1:0] tag_q;
    logic [CW-1:0]   infl_q;
    logic [CW:0]     booked;
    logic            accept;

    assign booked    = {1'b0, count} + {1'b0, infl_q};
    assign req_valid = booked < LIMIT;
    assign accept    = req_valid && req_ready;
    assign push      = rsp_valid && (rsp_tag == tag_q) && !flush;
    assign req_addr  = pc_q;
    assign req_tag   = tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= {RESET_PC[AW-1:2], 2'b00};
            tag_q  <= '0;
            infl_q <= '0;
        end else if (flush) begin
            pc_q   <= {flush_addr[AW-1:2], 2'b00};
            tag_q  <= tag_q + 1'b1;
            infl_q <= '0;
        end else begin
            if (accept)
                pc_q <= pc_q + AW'(4);
            infl_q <= infl_q + CW'(accept) - CW'(push);
        end
    end

    p_budget_r2: assert property (@(posedge clk) disable iff (rst)
        booked <= LIMIT);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && !flush) |=> req_addr == $past(req_addr) + AW'(4));

    p_new_tag_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> req_tag != $past(req_tag));

endmodule

// File: rtl/ipq_ring.sv
module ipq_ring
    import ipq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CW = 3,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  word_t         push_data,
    input  logic          pop,
    output logic [CW-1:0] count,
    output word_t         head_word,
    output word_t         next_word
);
    word_t         slot_q [DEPTH];
    logic [IW-1:0] head_q, tail_q, head_nx;
    logic [CW-1:0] cnt_q;

    function automatic logic [IW-1:0] bump(logic [IW-1:0] i);
        return (i == IW'(DEPTH-1)) ? '0 : i + 1'b1;
    endfunction

    assign head_nx   = bump(head_q);
    assign head_word = slot_q[head_q];
    assign next_word = slot_q[head_nx];
    assign count     = cnt_q;

    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++)
            if (push && tail_q == IW'(s))
                slot_q[s] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) tail_q <= bump(tail_q);
            if (pop)  head_q <= head_nx;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> cnt_q < CW'(DEPTH));

    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt_q != '0);

endmodule

// File: rtl/ipq_issue.sv
module ipq_issue
    import ipq_pkg::*;
#(
    parameter int CW = 3,
    parameter int AW = 32,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic [CW-1:0] count,
    input  word_t         head_word,
    input  word_t         next_word,
    input  logic          dec_ready,
    output logic          dec_valid,
    output word_t         dec_insn,
    output logic          dec_len32,
    output logic [AW-1:0] dec_pc,
    output logic          pop
);
    logic          half_q;
    logic [AW-1:0] pc_q;
    logic [CW+1:0] avail;
    parcel_t       lo, hi;
    issue_t        cand;
    logic          take;

    // halves held = two per filled slot, less one if the head's lower half was skipped
    assign avail = (count == '0) ? '0 : ({1'b0, count, 1'b0} - (CW+2)'(half_q));
    assign lo    = half_q ? head_word[31:16] : head_word[15:0];
    assign hi    = half_q ? next_word[15:0]  : head_word[31:16];
    assign cand  = assemble(lo, hi);

    assign dec_valid = (avail != '0) && (!cand.len32 || avail >= (CW+2)'(2));
    assign dec_insn  = cand.insn;
    assign dec_len32 = cand.len32;
    assign dec_pc    = pc_q;
    assign take      = dec_valid && dec_ready && !flush;
    assign pop       = take && (cand.len32 || half_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= RESET_PC[1];
            pc_q   <= {RESET_PC[AW-1:1], 1'b0};
        end else if (flush) begin
            half_q <= flush_addr[1];
            pc_q   <= {flush_addr[AW-1:1], 1'b0};
        end else if (take) begin
            pc_q   <= pc_q + (cand.len32 ? AW'(4) : AW'(2));
            half_q <= cand.len32 ? half_q : ~half_q;
        end
    end

    p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !dec_valid);

    p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
        take |=> dec_pc == $past(dec_pc) + ($past(dec_len32) ? AW'(4) : AW'(2)));

    p_span_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_len32 && half_q) |-> count >= CW'(2));

    p_short_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_len32) |-> dec_insn[31:16] == '0);

endmodule

// File: rtl/insn_prefetch_queue.sv
module insn_prefetch_queue
    import ipq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int AW = 32,
    parameter int TAGW = 2,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [AW-1:0]   flush_addr,
    output logic            fetch_req_valid,
    input  logic            fetch_req_ready,
    output logic [AW-1:0]   fetch_req_addr,
    output logic [TAGW-1:0] fetch_req_tag,
    input  logic            fetch_rsp_valid,
    input  logic [TAGW-1:0] fetch_rsp_tag,
    input  logic [31:0]     fetch_rsp_data,
    output logic            dec_valid,
    input  logic            dec_ready,
    output logic [31:0]     dec_insn,
    output logic            dec_len32,
    output logic [AW-1:0]   dec_pc
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0] count;
    logic          push, pop;
    word_t         head_word, next_word;

    ipq_fetch_ctl #(.DEPTH(DEPTH), .AW(AW), .TAGW(TAGW), .CW(CW), .RESET_PC(RESET_PC)) u_fetch (
        .clk(clk), .rst(rst), .flush(flush), .flush_addr(flush_addr), .count(count),
        .req_valid(fetch_req_valid), .req_ready(fetch_req_ready),
        .req_addr(fetch_req_addr), .req_tag(fetch_req_tag),
        .rsp_valid(fetch_rsp_valid), .rsp_tag(fetch_rsp_tag), .push(push)
    );

    ipq_ring #(.DEPTH(DEPTH), .CW(CW), .IW(IW)) u_ring (
        .clk(clk), .rst(rst), .flush(flush), .push(push), .push_data(fetch_rsp_data),
        .pop(pop), .count(count), .head_word(head_word), .next_word(next_word)
    );

    ipq_issue #(.CW(CW), .AW(AW), .RESET_PC(RESET_PC)) u_issue (
        .clk(clk), .rst(rst), .flush(flush), .flush_addr(flush_addr), .count(count),
        .head_word(head_word), .next_word(next_word), .dec_ready(dec_ready),
        .dec_valid(dec_valid), .dec_insn(dec_insn), .dec_len32(dec_len32),
        .dec_pc(dec_pc), .pop(pop)
    );

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !dec_valid);

endmodule

// File: tb/sim_insn_prefetch_queue.sv
`timescale 1ns/1ps
module sim_insn_prefetch_queue;
    localparam int QN = 64;

    logic        clk = 0;
    logic        rst = 1;
    logic        flush = 0;
    logic [31:0] flush_addr = '0;
    logic        fetch_req_valid;
    logic        fetch_req_ready = 0;
    logic [31:0] fetch_req_addr;
    logic [1:0]  fetch_req_tag;
    logic        fetch_rsp_valid = 0;
    logic [1:0]  fetch_rsp_tag = '0;
    logic [31:0] fetch_rsp_data = '0;
    logic        dec_valid;
    logic        dec_ready = 0;
    logic [31:0] dec_insn;
    logic        dec_len32;
    logic [31:0] dec_pc;

    always #2 clk = ~clk;

    insn_prefetch_queue u0 (
        .clk(clk), .rst(rst), .flush(flush), .flush_addr(flush_addr),
        .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
        .fetch_req_addr(fetch_req_addr), .fetch_req_tag(fetch_req_tag),
        .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_tag(fetch_rsp_tag),
        .fetch_rsp_data(fetch_rsp_data), .dec_valid(dec_valid), .dec_ready(dec_ready),
        .dec_insn(dec_insn), .dec_len32(dec_len32), .dec_pc(dec_pc)
    );

    int compared = 0, mismatched = 0, cyc = 0;
    int n_req = 0, n_iss = 0, stale_cnt = 0, last_due = 0;
    int qh = 0, qt = 0;
    logic [31:0] q_addr [QN];
    logic [1:0]  q_tag  [QN];
    int          q_due  [QN];
    logic [31:0] exp_pc = '0, exp_faddr = '0, first_tgt = '0;
    logic [1:0]  exp_tag = '0;
    bit pend_first = 0, got_cur = 0, done = 0;

    function automatic logic [31:0] memw(logic [31:0] a);
        logic [31:0] h;
        h = (a >> 2) * 32'h9E3779B1;
        h = h ^ (h >> 15);
        return h;
    endfunction

    function automatic logic [15:0] parcel(logic [31:0] a);
        logic [31:0] w;
        w = memw(a);
        return a[1] ? w[31:16] : w[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input bit fl, input logic [31:0] tgt, input bit drdy, input bit frdy, input bit ren);
        logic [15:0] p;
        logic [31:0] einsn;
        bit lng;
        int d;
        @(negedge clk);
        flush = fl; flush_addr = tgt; dec_ready = drdy; fetch_req_ready = frdy;
        fetch_rsp_valid = 0; got_cur = 0;
        if (ren && qh != qt && q_due[qh % QN] <= cyc) begin
            fetch_rsp_valid = 1;
            fetch_rsp_tag   = q_tag[qh % QN];
            fetch_rsp_data  = memw(q_addr[qh % QN]);
            if (q_tag[qh % QN] != exp_tag) stale_cnt++;
            else got_cur = 1;
            qh++;
        end
        #1;
        if (fetch_req_valid && frdy) begin
            chk(fetch_req_addr == exp_faddr, "R3 fetch address", fetch_req_addr, exp_faddr);
            chk(fetch_req_tag == exp_tag, "R3 fetch tag", {30'b0, fetch_req_tag}, {30'b0, exp_tag});
            d = cyc + 1 + int'($urandom % 4);
            if (d < last_due) d = last_due;
            last_due = d;
            q_addr[qt % QN] = fetch_req_addr;
            q_tag[qt % QN]  = fetch_req_tag;
            q_due[qt % QN]  = d;
            qt++;
            exp_faddr += 4;
            n_req++;
        end
        if (dec_valid && drdy && !fl) begin
            p = parcel(exp_pc);
            lng = (p[1:0] == 2'b11);
            einsn = lng ? {parcel(exp_pc + 2), p} : {16'h0, p};
            chk(dec_pc == exp_pc, "R10 issue pc", dec_pc, exp_pc);
            chk(dec_len32 == lng, "R4 length", {31'b0, dec_len32}, {31'b0, lng});
            chk(dec_insn == einsn, lng ? "R6 32-bit insn" : "R5 16-bit insn", dec_insn, einsn);
            if (pend_first) begin
                chk(dec_pc == first_tgt, "R8 first after redirect", dec_pc, first_tgt);
                pend_first = 0;
            end
            exp_pc += lng ? 4 : 2;
            n_iss++;
        end
        if (fl) begin
            exp_pc = tgt;
            exp_faddr = {tgt[31:2], 2'b00};
            exp_tag++;
            pend_first = 1;
            first_tgt = tgt;
        end
        cyc++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] t;
        logic [15:0] tp;
        int since;
        bit fl;
        int n0;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk(dec_valid == 0, "R1 idle decode", {31'b0, dec_valid}, 0);
        chk(fetch_req_valid == 1, "R1 request offered", {31'b0, fetch_req_valid}, 1);
        chk(fetch_req_addr == 32'h0, "R1 reset fetch address", fetch_req_addr, 0);
        chk(dec_pc == 32'h0, "R1 reset pc", dec_pc, 0);

        // R2: no responses, requests stop at capacity
        for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 0);
        chk(n_req == 6, "R2 requests at capacity", n_req, 6);
        chk(fetch_req_valid == 0, "R2 request withheld", {31'b0, fetch_req_valid}, 0);
        chk(dec_valid == 0, "R7 empty queue", {31'b0, dec_valid}, 0);

        // fill the queue
        for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 1);
        chk(fetch_req_valid == 0, "R2 full queue", {31'b0, fetch_req_valid}, 0);
        chk(dec_valid == 1, "R7 filled queue", {31'b0, dec_valid}, 1);

        // R11 latency: redirect to a word starting with a 16-bit parcel
        t = 32'h400;
        for (int k = 0; k < 64; k++) begin
            tp = parcel(t);
            if (tp[1:0] != 2'b11) break;
            t += 4;
        end
        step(1, t, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        chk(dec_valid == 0, "R8 emptied by redirect", {31'b0, dec_valid}, 0);
        chk(fetch_req_addr == t, "R8 fetch redirected", fetch_req_addr, t);
        for (int k = 0; k < 20; k++) begin
            step(0, 0, 0, 1, 1);
            if (got_cur) break;
        end
        step(0, 0, 0, 0, 0);
        chk(dec_valid == 1, "R11 response visible next cycle", {31'b0, dec_valid}, 1);
        chk(dec_pc == t, "R11 pc of first word", dec_pc, t);
        for (int i = 0; i < 30; i++) step(0, 0, 1, 1, 1);

        // R8: redirect into the upper half of a word
        step(1, 32'h0000_0902, 1, 1, 1);
        for (int i = 0; i < 40; i++) step(0, 0, 1, 1, 1);

        // R9: outstanding requests abandoned by a redirect
        step(1, 32'h0000_1200, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0);
        n0 = stale_cnt;
        step(1, 32'h0000_2046, 1, 0, 0);
        for (int i = 0; i < 60; i++) step(0, 0, 1, 1, 1);
        chk(stale_cnt > n0, "R9 stale responses delivered", stale_cnt, n0 + 1);

        // random mix
        since = 0;
        for (int i = 0; i < 2500; i++) begin
            fl = (since >= 20) && ($urandom % 40 == 0);
            t = {19'b0, 12'($urandom), 1'b0};
            step(fl, t, ($urandom % 10) < 7, ($urandom % 4) != 0, ($urandom % 5) != 0);
            since = fl ? 0 : since + 1;
        end
        for (int i = 0; i < 40; i++) step(0, 0, 1, 1, 1);
        chk(n_iss > 800, "R10 sustained issue", n_iss, 800);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule